// File: doc/BRIEF.md
# Crossover-Hunting Link Finder

This controller brings up a copper port whose cable may be straight or crossed. It drives a crossover select output, waits a dwell time, and then asks the PHY for its basic status word. If link is down, it flips the crossover setting and tries again. It gives up after a fixed number of attempts.

Once link is found, the controller queries the PHY further to learn the negotiated speed, duplex and pause ability. It then holds a four-flag summary and raises a done flag together with a pass/fail result. All PHY access goes through a simple request/acknowledge read port. Each request carries a 5-bit register address, and each acknowledge returns a 16-bit word. The serial management engine behind that port is outside this block.

Both the dwell time and the attempt limit are parameters. The dwell time is counted in clock cycles.

Top module: `mdix_link_hunter`

## Requirements
- R1: After reset, mgmt_req, xover_sel, done, pass, link_up, speed_100, full_duplex and pause_ok are all low.
- R2: A start pulse, sampled while idle or done, begins a hunt in straight mode (xover_sel low). The first read of the hunt is from register address 1.
- R3: Before every link-check read of address 1, mgmt_req stays low for at least DWELL_CYCLES cycles. The bench accepts a gap of DWELL_CYCLES to DWELL_CYCLES+2.
- R4: mgmt_req stays high with a stable mgmt_addr until the cycle in which mgmt_ack is high. The word on mgmt_rdata in that cycle is the result, and mgmt_req is low in the next cycle.
- R5: A link check whose bit 2 reads 0 is a failure. If attempts remain, xover_sel inverts before the next dwell, so successive attempts alternate 0,1,0,1...
- R6: After MAX_TRIES failed link checks, done goes high with pass low and all four status flags low. No further reads are issued, and xover_sel keeps the value of the last attempt.
- R7: After a successful link check, address 1 is read again. If bit 5 of that word is 0, the block finishes with pass=1 and link_up=1, speed_100, full_duplex and pause_ok stay 0, and no other reads follow.
- R8: If bit 5 is 1, address 31 is read and its bits 4:2 are decoded. Code 1 gives 10 Mb/s half duplex, code 5 gives 10 Mb/s full, code 2 gives 100 Mb/s half, and code 6 gives 100 Mb/s full. speed_100 and full_duplex are set to match.
- R9: Any other code in bits 4:2 of address 31 leaves speed_100 and full_duplex at 0.
- R10: Pause resolution is a chain of reads that applies only when the second address-1 word had both bit 3 and bit 5 set. The chain reads address 6, then address 4 if bit 0 of address 6 was 1, then address 5 if bit 10 of address 4 was 1. pause_ok is set only when bit 10 of address 5 is 1. Any break in the chain ends the block with pause_ok low.
- R11: done and the result flags hold until the next start. That start clears done, pass and all four status flags on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a hunt (accepted when idle or done) |
| mgmt_req | output | 1 | Read request to the management engine |
| mgmt_addr | output | 5 | PHY register address of the request |
| mgmt_ack | input | 1 | Read complete, data valid this cycle |
| mgmt_rdata | input | 16 | Register word returned with the acknowledge |
| xover_sel | output | 1 | Crossover select: 0 straight, 1 crossed |
| done | output | 1 | Hunt finished |
| pass | output | 1 | Link found (valid with done) |
| link_up | output | 1 | Status: link present |
| speed_100 | output | 1 | Status: 100 Mb/s negotiated |
| full_duplex | output | 1 | Status: full duplex negotiated |
| pause_ok | output | 1 | Status: pause agreed with partner |

## Verification
The bench builds the block with DWELL_CYCLES=20 and MAX_TRIES=6. With these values a complete failed hunt, with every attempt alternating the crossover setting, fits in a few hundred cycles. The dwell gaps before each link check can also be measured to the cycle. A PHY model in the bench answers each read after a chosen latency. Its link bit depends on the crossover setting and on the attempt number, which allows every branch of the speed decode and of the pause chain to be reached.

// File: rtl/mdix_hunt_pkg.sv
package mdix_hunt_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] ADR_BASIC_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] ADR_OUR_ADVERT = 5'd4;
    localparam logic [ADDR_W-1:0] ADR_PEER_ABIL  = 5'd5;
    localparam logic [ADDR_W-1:0] ADR_NEG_EXPAND = 5'd6;
    localparam logic [ADDR_W-1:0] ADR_VENDOR_SPD = 5'd31;

    localparam int BIT_LINK      = 2;
    localparam int BIT_NEG_ABLE  = 3;
    localparam int BIT_NEG_DONE  = 5;
    localparam int BIT_PEER_NEG  = 0;
    localparam int BIT_PAUSE     = 10;
    localparam int SPD_CODE_LSB  = 2;

    typedef enum logic [2:0] {
        H_IDLE,
        H_DWELL,
        H_ISSUE,
        H_WAIT,
        H_DONE
    } hunt_st_e;

    typedef enum logic [2:0] {
        Q_LINK,
        Q_CONFIRM,
        Q_SPEED,
        Q_EXPAN,
        Q_ADVERT,
        Q_PARTNER
    } query_e;

    typedef struct packed {
        logic link;
        logic fast;
        logic full;
        logic pause;
    } link_sum_t;

    function automatic logic [ADDR_W-1:0] query_addr(input query_e q);
        case (q)
            Q_SPEED:   return ADR_VENDOR_SPD;
            Q_EXPAN:   return ADR_NEG_EXPAND;
            Q_ADVERT:  return ADR_OUR_ADVERT;
            Q_PARTNER: return ADR_PEER_ABIL;
            default:   return ADR_BASIC_STAT;
        endcase
    endfunction

    function automatic link_sum_t decode_speed(input logic [2:0] code);
        link_sum_t s;
        s = '0;
        case (code)
            3'd1: begin s.fast = 1'b0; s.full = 1'b0; end
            3'd5: begin s.fast = 1'b0; s.full = 1'b1; end
            3'd2: begin s.fast = 1'b1; s.full = 1'b0; end
            3'd6: begin s.fast = 1'b1; s.full = 1'b1; end
            default: begin s.fast = 1'b0; s.full = 1'b0; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mdix_dwell_timer.sv
module mdix_dwell_timer #(
    parameter int DWELL_CYCLES = 250_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic fire
);
    localparam int CW = $clog2(DWELL_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_V = CW'(DWELL_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_V;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign fire = (cnt == CW'(1));

    // R3: an armed count walks down one per cycle
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        (cnt > CW'(1) && !load) |=> (cnt == $past(cnt) - 1'b1));

    initial begin
        a_r3_dwell_nonzero: assert (DWELL_CYCLES >= 1);
    end

endmodule

// File: rtl/mdix_mgmt_port.sv
module mdix_mgmt_port
    import mdix_hunt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [ADDR_W-1:0] launch_addr,
    output logic              mgmt_req,
    output logic [ADDR_W-1:0] mgmt_addr,
    input  logic              mgmt_ack,
    input  logic [DATA_W-1:0] mgmt_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mgmt_req  <= 1'b0;
            mgmt_addr <= '0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (launch) begin
                mgmt_req  <= 1'b1;
                mgmt_addr <= launch_addr;
            end else if (mgmt_req && mgmt_ack) begin
                mgmt_req <= 1'b0;
                rd_valid <= 1'b1;
                rd_data  <= mgmt_rdata;
            end
        end
    end

    // R4: request is held with its address until acknowledged
    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        (mgmt_req && !mgmt_ack) |=> (mgmt_req && $stable(mgmt_addr)));

    // R4: acknowledge ends the request and yields the word
    a_r4_ack_closes: assert property (@(posedge clk) disable iff (rst)
        (mgmt_req && mgmt_ack) |=> (!mgmt_req && rd_valid && rd_data == $past(mgmt_rdata)));

    // R4: sequencer only launches onto an idle port
    a_r4_launch_idle: assert property (@(posedge clk) disable iff (rst)
        launch |-> !mgmt_req);

endmodule

// File: rtl/mdix_link_summary.sv
module mdix_link_summary
    import mdix_hunt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      set_link,
    input  logic      load_spd,
    input  logic [2:0] spd_code,
    input  logic      set_pause,
    output link_sum_t sum
);
    link_sum_t dec;

    assign dec = decode_speed(spd_code);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum <= '0;
        end else begin
            if (set_link)  sum.link  <= 1'b1;
            if (set_pause) sum.pause <= 1'b1;
            if (load_spd) begin
                sum.fast <= dec.fast;
                sum.full <= dec.full;
            end
        end
    end

    // R11: a clear wipes the whole summary
    a_r11_clear_wipes: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sum == '0));

endmodule

// File: rtl/mdix_link_hunter.sv
module mdix_link_hunter
    import mdix_hunt_pkg::*;
#(
    parameter int DWELL_CYCLES = 250_000_000,
    parameter int MAX_TRIES    = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        mgmt_req,
    output logic [4:0]  mgmt_addr,
    input  logic        mgmt_ack,
    input  logic [15:0] mgmt_rdata,
    output logic        xover_sel,
    output logic        done,
    output logic        pass,
    output logic        link_up,
    output logic        speed_100,
    output logic        full_duplex,
    output logic        pause_ok
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);

    hunt_st_e          st, st_n;
    query_e            q, q_n;
    logic [TRY_W-1:0]  tries, tries_n;
    logic              xo, xo_n;
    logic              an_able, an_n;
    logic              done_q, done_n;
    logic              pass_q, pass_n;

    logic              tmr_load, tmr_fire;
    logic              launch;
    logic [ADDR_W-1:0] launch_addr;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              sum_clr, sum_link, sum_spd, sum_pause;
    link_sum_t         sum;

    mdix_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .fire (tmr_fire)
    );

    assign launch      = (st == H_ISSUE);
    assign launch_addr = query_addr(q);

    mdix_mgmt_port u_port (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_addr (launch_addr),
        .mgmt_req    (mgmt_req),
        .mgmt_addr   (mgmt_addr),
        .mgmt_ack    (mgmt_ack),
        .mgmt_rdata  (mgmt_rdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data)
    );

    mdix_link_summary u_sum (
        .clk       (clk),
        .rst       (rst),
        .clr       (sum_clr),
        .set_link  (sum_link),
        .load_spd  (sum_spd),
        .spd_code  (rd_data[SPD_CODE_LSB +: 3]),
        .set_pause (sum_pause),
        .sum       (sum)
    );

    always_comb begin
        logic wrap_up;
        wrap_up   = 1'b0;
        st_n      = st;
        q_n       = q;
        tries_n   = tries;
        xo_n      = xo;
        an_n      = an_able;
        done_n    = done_q;
        pass_n    = pass_q;
        tmr_load  = 1'b0;
        sum_clr   = 1'b0;
        sum_link  = 1'b0;
        sum_spd   = 1'b0;
        sum_pause = 1'b0;
        case (st)
            H_IDLE, H_DONE: begin
                if (start) begin
                    st_n     = H_DWELL;
                    q_n      = Q_LINK;
                    tries_n  = '0;
                    xo_n     = 1'b0;
                    an_n     = 1'b0;
                    done_n   = 1'b0;
                    pass_n   = 1'b0;
                    tmr_load = 1'b1;
                    sum_clr  = 1'b1;
                end
            end
            H_DWELL: begin
                if (tmr_fire) st_n = H_ISSUE;
            end
            H_ISSUE: begin
                st_n = H_WAIT;
            end
            H_WAIT: begin
                if (rd_valid) begin
                    case (q)
                        Q_LINK: begin
                            if (rd_data[BIT_LINK]) begin
                                q_n  = Q_CONFIRM;
                                st_n = H_ISSUE;
                            end else if (tries == LAST_TRY) begin
                                st_n   = H_DONE;
                                done_n = 1'b1;
                                pass_n = 1'b0;
                            end else begin
                                tries_n  = tries + 1'b1;
                                xo_n     = ~xo;
                                tmr_load = 1'b1;
                                st_n     = H_DWELL;
                            end
                        end
                        Q_CONFIRM: begin
                            an_n = rd_data[BIT_NEG_ABLE];
                            if (rd_data[BIT_NEG_DONE]) begin
                                q_n  = Q_SPEED;
                                st_n = H_ISSUE;
                            end else begin
                                wrap_up = 1'b1;
                            end
                        end
                        Q_SPEED: begin
                            sum_spd = 1'b1;
                            if (an_able) begin
                                q_n  = Q_EXPAN;
                                st_n = H_ISSUE;
                            end else begin
                                wrap_up = 1'b1;
                            end
                        end
                        Q_EXPAN: begin
                            if (rd_data[BIT_PEER_NEG]) begin
                                q_n  = Q_ADVERT;
                                st_n = H_ISSUE;
                            end else begin
                                wrap_up = 1'b1;
                            end
                        end
                        Q_ADVERT: begin
                            if (rd_data[BIT_PAUSE]) begin
                                q_n  = Q_PARTNER;
                                st_n = H_ISSUE;
                            end else begin
                                wrap_up = 1'b1;
                            end
                        end
                        default: begin
                            sum_pause = rd_data[BIT_PAUSE];
                            wrap_up   = 1'b1;
                        end
                    endcase
                end
            end
            default: st_n = H_IDLE;
        endcase
        if (wrap_up) begin
            sum_link = 1'b1;
            done_n   = 1'b1;
            pass_n   = 1'b1;
            st_n     = H_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= H_IDLE;
            q       <= Q_LINK;
            tries   <= '0;
            xo      <= 1'b0;
            an_able <= 1'b0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            st      <= st_n;
            q       <= q_n;
            tries   <= tries_n;
            xo      <= xo_n;
            an_able <= an_n;
            done_q  <= done_n;
            pass_q  <= pass_n;
        end
    end

    assign xover_sel   = xo;
    assign done        = done_q;
    assign pass        = pass_q;
    assign link_up     = sum.link;
    assign speed_100   = sum.fast;
    assign full_duplex = sum.full;
    assign pause_ok    = sum.pause;

    // R3: a link-check read is only launched right after the dwell expires
    a_r3_dwell_before_check: assert property (@(posedge clk) disable iff (rst)
        (st == H_ISSUE && q == Q_LINK) |-> $past(tmr_fire));

    // R5: crossover never moves while a read is outstanding
    a_r5_xover_quiet_in_read: assert property (@(posedge clk) disable iff (rst)
        mgmt_req |-> $stable(xover_sel));

    // R6: a failed hunt reports no status
    a_r6_fail_is_blank: assert property (@(posedge clk) disable iff (rst)
        (done && !pass) |-> !(link_up || speed_100 || full_duplex || pause_ok));

    // R6: the attempt counter stays within the limit
    a_r6_tries_bounded: assert property (@(posedge clk) disable iff (rst)
        tries < TRY_W'(MAX_TRIES));

    // R6: nothing is requested once finished
    a_r6_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !mgmt_req);

    // R10: pause is never claimed without link
    a_r10_pause_needs_link: assert property (@(posedge clk) disable iff (rst)
        pause_ok |-> link_up);

    // R11: done persists until a new start
    a_r11_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

endmodule

// File: tb/mdix_link_hunter_tb.sv
`timescale 1ns/1ps
module mdix_link_hunter_tb;

    localparam int DWELL = 20;
    localparam int TRIES = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mgmt_req;
    logic [4:0]  mgmt_addr;
    logic        mgmt_ack = 1'b0;
    logic [15:0] mgmt_rdata = '0;
    logic        xover_sel, done, pass, link_up, speed_100, full_duplex, pause_ok;

    mdix_link_hunter #(.DWELL_CYCLES(DWELL), .MAX_TRIES(TRIES)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .mgmt_req(mgmt_req), .mgmt_addr(mgmt_addr),
        .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata),
        .xover_sel(xover_sel), .done(done), .pass(pass),
        .link_up(link_up), .speed_100(speed_100),
        .full_duplex(full_duplex), .pause_ok(pause_ok)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // PHY model knobs
    int want_x = 0;      // crossover value that gives link, -1 never
    int need_n = 0;      // number of address-1 reads before link may show
    logic neg_done = 1'b0, neg_able = 1'b0;
    logic [2:0] spd_code = 3'd0;
    logic peer_neg = 1'b0, adv_pause = 1'b0, peer_pause = 1'b0;
    int lat = 1;

    int log_addr [0:63];
    int log_xo   [0:63];
    int log_gap  [0:63];
    int log_n = 0;
    int r1cnt = 0;
    int gap = 0;

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] phy_word(input int a, input int xo, input int n1);
        logic [15:0] w;
        w = 16'hA140;
        case (a)
            1: begin
                w[2] = (want_x >= 0) && (xo == want_x) && (n1 >= need_n);
                w[3] = neg_able;
                w[5] = neg_done;
            end
            31: w[4:2] = spd_code;
            6:  w[0]   = peer_neg;
            4:  w[10]  = adv_pause;
            5:  w[10]  = peer_pause;
            default: ;
        endcase
        return w;
    endfunction

    task automatic responder();
        forever begin
            @(negedge clk); #1;
            if (start) begin
                gap = 0;
            end else if (mgmt_req) begin
                int a;
                int x;
                a = int'(mgmt_addr);
                x = int'(xover_sel);
                if (log_n < 64) begin
                    log_addr[log_n] = a;
                    log_xo[log_n]   = x;
                    log_gap[log_n]  = gap;
                end
                log_n++;
                repeat (lat - 1) begin @(negedge clk); #1; end
                mgmt_rdata = phy_word(a, x, r1cnt);
                if (a == 1) r1cnt++;
                mgmt_ack = 1'b1;
                @(negedge clk); #1;
                mgmt_ack = 1'b0;
                gap = 0;
            end else begin
                gap++;
            end
        end
    endtask

    task automatic run_hunt();
        int w;
        log_n = 0;
        r1cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: start clears the previous result
        chk("R11 done cleared by start", int'(done), 0);
        chk("R11 status cleared by start", int'({link_up, speed_100, full_duplex, pause_ok}), 0);
        w = 0;
        while (!done && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk("R6 hunt finished", int'(done), 1);
        @(negedge clk);
        #2;
    endtask

    task automatic check_seq(input string tag, input int exp_a [8], input int n);
        chk({tag, " read count"}, log_n, n);
        for (int i = 0; i < n && i < log_n; i++)
            chk({tag, " read address"}, log_addr[i], exp_a[i]);
    endtask

    task automatic check_gap(input string tag, input int idx);
        total++;
        if (log_gap[idx] < DWELL || log_gap[idx] > DWELL + 2) begin
            bad++;
            $display("FAIL %s gap[%0d] got=%0d exp=%0d..%0d", tag, idx, log_gap[idx], DWELL, DWELL + 2);
        end
    endtask

    task automatic set_phy(input int wx, input int nn, input logic nd, input logic na,
                           input logic [2:0] sc, input logic pn, input logic ap, input logic pp);
        want_x = wx; need_n = nn; neg_done = nd; neg_able = na;
        spd_code = sc; peer_neg = pn; adv_pause = ap; peer_pause = pp;
    endtask

    task automatic t_reset();
        chk("R1 reset req", int'(mgmt_req), 0);
        chk("R1 reset xover", int'(xover_sel), 0);
        chk("R1 reset done/pass", int'({done, pass}), 0);
        chk("R1 reset status", int'({link_up, speed_100, full_duplex, pause_ok}), 0);
    endtask

    task automatic t_cross_full();
        int e [8] = '{1, 1, 1, 31, 6, 4, 5, 0};
        lat = 2;
        set_phy(1, 0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1);
        run_hunt();
        check_seq("R10 full chain", e, 7);
        chk("R2 first attempt straight", log_xo[0], 0);
        chk("R5 second attempt crossed", log_xo[1], 1);
        check_gap("R3 dwell first", 0);
        check_gap("R3 dwell second", 1);
        chk("R7 pass", int'(pass), 1);
        chk("R8 code6 flags", int'({link_up, speed_100, full_duplex}), 7);
        chk("R10 pause agreed", int'(pause_ok), 1);
    endtask

    task automatic t_fail();
        lat = 1;
        set_phy(-1, 0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1);
        run_hunt();
        chk("R6 attempts", log_n, TRIES);
        for (int i = 0; i < TRIES; i++) begin
            chk("R6 only link reads", log_addr[i], 1);
            chk("R5 alternation", log_xo[i], i % 2);
        end
        check_gap("R3 dwell late attempt", TRIES - 1);
        chk("R6 fail result", int'({done, pass}), 2);
        chk("R6 fail status blank", int'({link_up, speed_100, full_duplex, pause_ok}), 0);
        chk("R6 xover kept", int'(xover_sel), (TRIES - 1) % 2);
        repeat (100) @(negedge clk);
        chk("R6 no reads after fail", log_n, TRIES);
        chk("R11 done held", int'(done), 1);
    endtask

    task automatic t_no_neg();
        int e [8] = '{1, 1, 1, 1, 0, 0, 0, 0};
        lat = 3;
        set_phy(0, 2, 1'b0, 1'b1, 3'd6, 1'b1, 1'b1, 1'b1);
        run_hunt();
        check_seq("R7 no negotiation", e, 4);
        chk("R5 third attempt straight", log_xo[2], 0);
        check_gap("R3 dwell third", 2);
        chk("R7 pass", int'(pass), 1);
        chk("R7 link only", int'({link_up, speed_100, full_duplex, pause_ok}), 8);
    endtask

    task automatic t_code(input logic [2:0] c, input int exp_fast, input int exp_full, input string tag);
        int e [8] = '{1, 1, 31, 0, 0, 0, 0, 0};
        lat = 1;
        set_phy(0, 0, 1'b1, 1'b0, c, 1'b1, 1'b1, 1'b1);
        run_hunt();
        check_seq({tag, " seq"}, e, 3);
        chk({tag, " speed_100"}, int'(speed_100), exp_fast);
        chk({tag, " full_duplex"}, int'(full_duplex), exp_full);
        chk({tag, " link, no pause"}, int'({link_up, pause_ok}), 2);
    endtask

    task automatic t_chain_break(input logic pn, input logic ap, input logic pp, input int n, input string tag);
        int e [8] = '{1, 1, 31, 6, 4, 5, 0, 0};
        lat = 2;
        set_phy(0, 0, 1'b1, 1'b1, 3'd1, pn, ap, pp);
        run_hunt();
        check_seq(tag, e, n);
        chk({tag, " pause"}, int'(pause_ok), 0);
        chk({tag, " link"}, int'({pass, link_up}), 3);
    endtask

    initial begin
        fork
            responder();
        join_none
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cross_full();
        t_fail();
        t_no_neg();
        t_code(3'd1, 0, 0, "R8 code1");
        t_code(3'd5, 0, 1, "R8 code5");
        t_code(3'd2, 1, 0, "R8 code2");
        t_code(3'd3, 0, 0, "R9 code3");
        t_code(3'd7, 0, 0, "R9 code7");
        t_chain_break(1'b0, 1'b1, 1'b1, 4, "R10 no peer negotiation");
        t_chain_break(1'b1, 1'b0, 1'b1, 5, "R10 no local pause");
        t_chain_break(1'b1, 1'b1, 1'b0, 6, "R10 peer lacks pause");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule